// File: doc/BRIEF.md
# Multi-Channel Fault Input Filter

This block conditions four asynchronous fault pins before any fault-handling logic acts on them. Each pin passes through a two-flop synchronizer. A per-channel polarity bit then turns it into an active-high fault level. A digital glitch filter follows, and it is shared by all channels. The filter samples each conditioned input once every programmable number of clock cycles. It accepts a change of level only after a run of consecutive samples that all show the new level. A period of zero turns the filter off, so the conditioned level passes straight through.

The filtered levels are brought out live on a port and in a status register. Each channel also has a sticky fault flag, which is set when its filtered level becomes active and is cleared when software writes 1 to it. All flags come out of reset set. A test bit injects a simulated fault ahead of every filter, so it takes the same path as a real fault. Software reaches the block through a simple strobe port with a combinational read path.

Top module: `fault_input_filter`

## Requirements
- R1: After reset all four fault flags are 1. The filtered levels are not forced by reset and follow the live conditioned inputs, so with all pins inactive they read 0000.
- R2: Each pin is synchronized by two flops and then converted to active-high by its polarity bit. Polarity bits are control register (address 0) bits [3:0]: 0 means the pin is active-low, 1 means active-high. In bypass, a pin change shows on `fault_level` after the second rising clock edge.
- R3: When the filter period (filter register, address 1, bits [7:0]) is 0, which is the reset value, the filter is bypassed and `fault_level` follows the conditioned input combinationally.
- R4: With a period P > 0 and a count code C (address 1, bits [10:8]), a new level is accepted after N = C + 3 consecutive agreeing samples. Code 0 gives 3 samples and code 7 gives 10. A write to address 1 restarts the sample prescaler, and the first sample falls on the (P+1)-th edge after the write. If the pin changes together with the write, the level changes at edge N*P+1.
- R5: A disagreeing run shorter than N samples is discarded: a sample equal to the accepted level restarts the count, and the filtered level does not change.
- R6: While the test bit (address 0, bit 4) is 1, an active fault is forced into the input of all four filters, upstream of the filter. Clearing the bit removes it.
- R7: A fault flag is set on the clock edge that follows a rising edge of its filtered level, which is within 2 cycles. It stays set after the level falls.
- R8: Writing address 2 with bit n = 1 clears flag n. Bits written as 0 leave their flags unchanged. A read of address 2 returns the flags in bits [3:0] and the filtered levels in bits [7:4].
- R9: When a set event and a write-1-to-clear reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_pin | input | 4 | Raw asynchronous fault pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 control, 1 filter, 2 status) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when not reading |
| fault_flag | output | 4 | Sticky fault flags |
| fault_level | output | 4 | Filtered active-high fault levels |

## Verification
Pin transitions are driven in bypass to measure the fixed two-edge synchronizer delay, and with both polarity settings to show that the conversion depends on the channel. In filtered mode a step on the pin is aligned with the period write. The level is then checked one edge before and on edge N*P+1 for code 0 and for code 7, which separates a correct sample-count offset from an off-by-one count and a wrong prescaler alignment. A glitch that spans fewer samples than needed shows that short runs are rejected. The test bit is applied in bypass and in filtered mode, and the delay in filtered mode shows that the injection sits ahead of the filter rather than at its output.

// File: rtl/fif_pkg.sv
// Package: shared constants for the fault input filter.
// Assumes: register addresses are decoded on a 2-bit bus address.
package fif_pkg;
    localparam int NUM_CH      = 4;
    localparam int PERIOD_W    = 8;
    localparam int CODE_W      = 3;
    localparam int BUS_W       = 16;
    localparam int BUS_AW      = 2;
    localparam int MIN_SAMPLES = 3;

    typedef enum logic [BUS_AW-1:0] {
        REG_CTRL = 2'd0,
        REG_FILT = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } fif_reg_e;
endpackage

// File: rtl/fif_prescaler.sv
// Module: fif_prescaler
// Produces a one-cycle sample strobe every PERIOD_W-bit 'period' cycles.
// Assumes: period == 0 means bypass (no strobe); 'restart' clears the
// count on the same edge that loads a new period.
module fif_prescaler #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic                restart,
    output logic                sample_stb
);
    logic [PERIOD_W-1:0] cnt_q;
    logic                last_tick;

    // Last cycle of a period, suppressed while restarting or bypassed.
    always_comb begin
        last_tick  = (period != '0) && (cnt_q == period - 1'b1);
        sample_stb = last_tick && !restart;
    end

    // Free-running period counter with restart on period write.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || period == '0 || last_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) |-> (cnt_q < period));
endmodule

// File: rtl/fif_channel.sv
// Module: fif_channel
// One fault channel: two-flop synchronizer, polarity conversion, test
// injection, and a consecutive-sample filter driven by a shared strobe.
// Assumes: pin_raw is asynchronous; the synchronizer flops carry no reset,
// and the accepted level tracks the live input during reset, so reset
// never forces the filtered level.
module fif_channel #(
    parameter int CODE_W = 3,
    parameter int OFFSET = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_raw,
    input  logic              active_high,
    input  logic              force_fault,
    input  logic              bypass,
    input  logic              sample_stb,
    input  logic [CODE_W-1:0] cnt_code,
    output logic              level
);
    localparam int NEED_MAX = (1 << CODE_W) - 1 + OFFSET;
    localparam int NEED_W   = $clog2(NEED_MAX + 1);

    logic              sync1_q, sync2_q;
    logic              cond;
    logic              accepted_q;
    logic [NEED_W-1:0] run_q;
    logic [NEED_W-1:0] need;
    logic [NEED_W-1:0] run_next;

    // Two-flop synchronizer for the raw pin.
    always_ff @(posedge clk) begin
        sync1_q <= pin_raw;
        sync2_q <= sync1_q;
    end

    // Polarity conversion to active-high, plus injected test fault.
    always_comb begin
        cond     = (active_high ? sync2_q : !sync2_q) || force_fault;
        need     = NEED_W'(cnt_code) + NEED_W'(OFFSET);
        run_next = run_q + 1'b1;
    end

    // Consecutive-sample filter; any agreeing sample restarts the run.
    always_ff @(posedge clk) begin
        if (!rst_n || bypass) begin
            accepted_q <= cond;
            run_q      <= '0;
        end else if (sample_stb) begin
            if (cond == accepted_q) begin
                run_q <= '0;
            end else if (run_next >= need) begin
                accepted_q <= cond;
                run_q      <= '0;
            end else begin
                run_q <= run_next;
            end
        end
    end

    // Bypass passes the conditioned input; otherwise the accepted level.
    assign level = bypass ? cond : accepted_q;

    // R4
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !sample_stb) |=> $stable(accepted_q));

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < need);
endmodule

// File: rtl/fault_input_filter.sv
// Module: fault_input_filter (top)
// Four-channel fault input conditioner with shared filter settings,
// sticky write-1-to-clear flags and a simple strobe register port.
// Register map: 0 control {test[4], polarity[3:0]}, 1 filter
// {code[10:8], period[7:0]}, 2 status {level[7:4], flags[3:0]}.
// Assumes: reads are combinational and happen while bus_rd is high.
module fault_input_filter
    import fif_pkg::*;
#(
    parameter int NCH    = NUM_CH,
    parameter int PER_W  = PERIOD_W,
    parameter int CNT_W  = CODE_W,
    parameter int DATA_W = BUS_W,
    parameter int ADDR_W = BUS_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    fault_pin,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    fault_flag,
    output logic [NCH-1:0]    fault_level
);
    localparam int CODE_LSB = PER_W;
    localparam int USED_W   = PER_W + CNT_W;

    logic [NCH-1:0]   pol_q;
    logic             test_q;
    logic [PER_W-1:0] period_q;
    logic [CNT_W-1:0] code_q;
    logic [NCH-1:0]   flag_q;
    logic [NCH-1:0]   level_prev_q;
    logic [NCH-1:0]   set_evt;
    logic [NCH-1:0]   clr_req;
    logic             wr_ctrl, wr_filt, wr_stat;
    logic             sample_stb;
    logic             bypass;
    logic             wdata_unused;

    // Write decode and shared filter mode.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
        wr_filt = bus_wr && (bus_addr == ADDR_W'(REG_FILT));
        wr_stat = bus_wr && (bus_addr == ADDR_W'(REG_STAT));
        bypass  = (period_q == '0);
        clr_req = wr_stat ? bus_wdata[NCH-1:0] : '0;
    end

    assign wdata_unused = ^bus_wdata[DATA_W-1:USED_W];

    // Control and filter configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q    <= '0;
            test_q   <= 1'b0;
            period_q <= '0;
            code_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                pol_q  <= bus_wdata[NCH-1:0];
                test_q <= bus_wdata[NCH];
            end
            if (wr_filt) begin
                period_q <= bus_wdata[PER_W-1:0];
                code_q   <= bus_wdata[CODE_LSB +: CNT_W];
            end
        end
    end

    fif_prescaler #(.PERIOD_W(PER_W)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .period     (period_q),
        .restart    (wr_filt),
        .sample_stb (sample_stb)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        fif_channel #(.CODE_W(CNT_W), .OFFSET(MIN_SAMPLES)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_raw     (fault_pin[ch]),
            .active_high (pol_q[ch]),
            .force_fault (test_q),
            .bypass      (bypass),
            .sample_stb  (sample_stb),
            .cnt_code    (code_q),
            .level       (fault_level[ch])
        );
    end

    // Rising edge of each filtered level raises a set event.
    always_ff @(posedge clk) begin
        level_prev_q <= fault_level;
    end
    assign set_evt = fault_level & ~level_prev_q;

    // Sticky flags: reset to all ones, write-1-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '1;
        end else begin
            flag_q <= (flag_q & ~clr_req) | set_evt;
        end
    end
    assign fault_flag = flag_q;

    // Combinational register read-back.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(REG_CTRL): begin
                    bus_rdata[NCH-1:0] = pol_q;
                    bus_rdata[NCH]     = test_q;
                end
                ADDR_W'(REG_FILT): begin
                    bus_rdata[PER_W-1:0]        = period_q;
                    bus_rdata[CODE_LSB +: CNT_W] = code_q;
                end
                ADDR_W'(REG_STAT): begin
                    bus_rdata[NCH-1:0]   = flag_q;
                    bus_rdata[NCH +: NCH] = fault_level;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt != '0) |=> ((fault_flag & $past(set_evt)) == $past(set_evt)));

    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && ((clr_req & ~set_evt) != '0))
            |=> ((fault_flag & $past(clr_req & ~set_evt)) == '0));

    // R7
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((fault_flag & ~$past(fault_flag) & ~$past(set_evt)) == '0));
endmodule

// File: tb/fault_input_filter_test.sv
// Directed bench for fault_input_filter: one task per scenario.
module fault_input_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fault_pin = 4'hF;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [3:0]  fault_flag;
    logic [3:0]  fault_level;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fault_input_filter uut (
        .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fault_flag(fault_flag), .fault_level(fault_level)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 16'h0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        check("R1 flags", {12'h0, fault_flag}, 16'h000F);
        check("R1 level", {12'h0, fault_level}, 16'h0000);
        reg_read(2'd2, d);
        check("R1 status read", d, 16'h000F);
        reg_read(2'd1, d);
        check("R3 period default", d, 16'h0000);
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        reg_write(2'd2, 16'h0000);
        check("R8 write0 no effect", {12'h0, fault_flag}, 16'h000F);
        reg_write(2'd2, 16'h0005);
        check("R8 partial clear", {12'h0, fault_flag}, 16'h000A);
        reg_write(2'd2, 16'h000A);
        reg_read(2'd2, d);
        check("R8 all cleared", d, 16'h0000);
    endtask

    task automatic t_bypass_sync();
        fault_pin[0] = 1'b0;
        edges(1);
        check("R2 sync stage 1", {12'h0, fault_level}, 16'h0000);
        edges(1);
        check("R3 bypass level", {12'h0, fault_level}, 16'h0001);
        check("R7 flag not yet", {12'h0, fault_flag}, 16'h0000);
        edges(1);
        check("R7 flag set", {12'h0, fault_flag}, 16'h0001);
        fault_pin[0] = 1'b1;
        edges(3);
        check("R7 flag sticky", {12'h0, fault_flag}, 16'h0001);
        check("R2 level released", {12'h0, fault_level}, 16'h0000);
        reg_write(2'd2, 16'h000F);
    endtask

    task automatic t_set_wins();
        fault_pin[1] = 1'b0;
        edges(2);
        reg_write(2'd2, 16'h0002);
        check("R9 set beats clear", {12'h0, fault_flag}, 16'h0002);
        fault_pin[1] = 1'b1;
        edges(3);
        reg_write(2'd2, 16'h000F);
        check("R8 clear after", {12'h0, fault_flag}, 16'h0000);
    endtask

    task automatic t_polarity();
        logic [15:0] d;
        reg_write(2'd0, 16'h0004);
        check("R2 active-high ch2", {12'h0, fault_level}, 16'h0004);
        reg_read(2'd2, d);
        check("R8 status level field", d, 16'h0040);
        reg_write(2'd0, 16'h0000);
        edges(1);
        reg_write(2'd2, 16'h000F);
        check("R2 back to active-low", {12'h0, fault_level}, 16'h0000);
    endtask

    task automatic t_test_bit_bypass();
        reg_write(2'd0, 16'h0010);
        check("R6 forced all", {12'h0, fault_level}, 16'h000F);
        edges(1);
        check("R6 flags set", {12'h0, fault_flag}, 16'h000F);
        reg_write(2'd0, 16'h0000);
        check("R6 removed", {12'h0, fault_level}, 16'h0000);
        reg_write(2'd2, 16'h000F);
    endtask

    task automatic t_filter(input int per, input int code, input string tag);
        int n = code + 3;
        fault_pin[0] = 1'b0;
        reg_write(2'd1, 16'((code << 8) | per));
        edges(n * per - 1);
        check({"R4 not yet ", tag}, {12'h0, fault_level}, 16'h0000);
        edges(1);
        check({"R4 accepted ", tag}, {12'h0, fault_level}, 16'h0001);
        check({"R7 flag lag ", tag}, {12'h0, fault_flag}, 16'h0000);
        edges(1);
        check({"R7 flag ", tag}, {12'h0, fault_flag}, 16'h0001);
        fault_pin[0] = 1'b1;
        edges(n * per + 4);
        check({"R4 release ", tag}, {12'h0, fault_level}, 16'h0000);
        check({"R7 sticky ", tag}, {12'h0, fault_flag}, 16'h0001);
        reg_write(2'd1, 16'h0000);
        reg_write(2'd2, 16'h000F);
    endtask

    task automatic t_glitch();
        reg_write(2'd1, 16'h0005);
        fault_pin[3] = 1'b0;
        edges(7);
        fault_pin[3] = 1'b1;
        edges(30);
        check("R5 glitch level", {12'h0, fault_level}, 16'h0000);
        check("R5 glitch flag", {12'h0, fault_flag}, 16'h0000);
        reg_write(2'd1, 16'h0000);
    endtask

    task automatic t_test_bit_filtered();
        reg_write(2'd1, 16'h0002);
        reg_write(2'd0, 16'h0010);
        check("R6 delayed by filter", {12'h0, fault_level}, 16'h0000);
        edges(10);
        check("R6 through filter", {12'h0, fault_level}, 16'h000F);
        reg_write(2'd0, 16'h0000);
        edges(10);
        check("R6 filtered release", {12'h0, fault_level}, 16'h0000);
        reg_write(2'd1, 16'h0000);
        reg_write(2'd2, 16'h000F);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        edges(1);
        t_reset_state();
        t_w1c();
        t_bypass_sync();
        t_set_wins();
        t_polarity();
        t_test_bit_bypass();
        t_filter(5, 0, "code0");
        t_filter(2, 7, "code7");
        t_glitch();
        t_test_bit_filtered();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule